// File: doc/BRIEF.md
# Multiplexed Video Input Formatter

This block sits in front of a three-channel video converter. It takes 10-bit samples on up to three input ports and delivers one registered triplet of component samples per output slot. The first component is luma or green, the second is Cb or blue, and the third is Cr or red. It handles three input arrangements: three parallel ports carrying 4:4:4 data, two ports carrying 4:2:2 YCbCr, and a single port carrying interleaved 4:2:2 YCbCr. In the 4:2:2 arrangements the block demultiplexes the chroma into holding registers. It then presents the chroma alongside every luma sample and pulses a valid strobe with each new luma or 4:4:4 sample.

Two configuration pins choose the arrangement. In generic mode the block follows these pins continuously. In video mode it samples them once, on the second clock edge after each change of the active-low sync input. Two active-low inputs override the data path: sync, which wins when both are low, drives the outputs to zero, and blank drives the outputs to the blanking codes of the current colour space.

Top module: `mux_video_formatter`

## Requirements
- R1: While rst_n is low, all three component outputs, out_valid and sync_flag are 0, and they go to 0 as soon as reset is asserted, without waiting for a clock.
- R2: With the format set to 00 (GBR 4:4:4) or 01 (YCbCr 4:4:4), all three outputs are loaded from port_a, port_b and port_c on every rising clock edge while active, with one cycle of latency and out_valid high.
- R3: With format 10 (2x10 4:2:2), port_a carries Y on every edge, and port_c alternates Cb then Cr. Each edge presents {Y, newest Cb, newest Cr}, with out_valid high every cycle. port_b is ignored.
- R4: With format 11 (1x10 4:2:2), port_a carries the repeating order Cb, Y, Cr, Y. A triplet {Y, held Cb, held Cr} is presented with out_valid only on the Y edges. On the chroma edges the outputs hold and out_valid is 0. Ports b and c are ignored.
- R5: Active means both sync_n and blank_n are high. In the 4:2:2 formats the sample order restarts at its first element on the first rising edge on which the block is active after being inactive. Held chroma reads as 0x200 after any inactive edge.
- R6: When blank_n is low and sync_n is high, the outputs become 0x040/0x040/0x040 in format 00, or 0x040/0x200/0x200 otherwise, with out_valid 0. This also applies in generic mode.
- R7: When sync_n is low, all outputs become 0 and out_valid is 0, whatever blank_n is. In video mode (generic_mode = 0), sync_flag is 1 one cycle later.
- R8: In video mode, the format in use is the value of {cfg_hi, cfg_lo} sampled on the second rising edge after sync_n changes. Pin changes at any other edge have no effect.
- R9: In generic mode (generic_mode = 1), the format follows {cfg_hi, cfg_lo} on every edge, and sync_flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| generic_mode | input | 1 | 1 = follow format pins continuously, 0 = latch after sync changes |
| cfg_hi | input | 1 | Format select, upper bit |
| cfg_lo | input | 1 | Format select, lower bit |
| sync_n | input | 1 | Active-low sync override |
| blank_n | input | 1 | Active-low blanking override |
| port_a | input | DW | Y/G port, also the single multiplexed port |
| port_b | input | DW | Cb/B port in 4:4:4 |
| port_c | input | DW | Cr/R port in 4:4:4, chroma port in 2x10 mode |
| comp0_out | output | DW | Y/G component |
| comp1_out | output | DW | Cb/B component |
| comp2_out | output | DW | Cr/R component |
| out_valid | output | 1 | Pulses when a new Y or 4:4:4 triplet is presented |
| sync_flag | output | 1 | Registered sync indication in video mode |

## Verification
The bench builds the block with its default sample width of 10 bits. At this width the blanking codes land on 0x040 and 0x200, and the all-ones pattern 0x3FF reaches the top of the range, so the saturation corners are covered. Chroma values on the ports the 4:2:2 formats ignore are set to all ones, so any leak shows up directly. With the 10-bit width, video-mode latching can be timed edge by edge through the blanking codes alone.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  typedef enum logic [1:0] {
    FMT_GBR444  = 2'b00,
    FMT_YC444   = 2'b01,
    FMT_YC422_2 = 2'b10,
    FMT_YC422_1 = 2'b11
  } fmt_e;
endpackage

// File: rtl/vfmt_mode_ctl.sv
module vfmt_mode_ctl
  import vfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       generic_mode,
  input  logic [1:0] cfg,
  input  logic       sync_n,
  output fmt_e       fmt_eff
);
  logic sync_d_q, sync_d_n;
  logic pend_q, pend_n;
  fmt_e mode_q, mode_n;

  // Edge 1 after a sync change arms the capture; edge 2 performs it.
  always_comb begin
    sync_d_n = sync_n;
    pend_n   = (sync_n != sync_d_q);
    mode_n   = pend_q ? fmt_e'(cfg) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d_q <= 1'b1;
      pend_q   <= 1'b0;
      mode_q   <= FMT_GBR444;
    end else begin
      sync_d_q <= sync_d_n;
      pend_q   <= pend_n;
      mode_q   <= mode_n;
    end
  end

  assign fmt_eff = generic_mode ? fmt_e'(cfg) : mode_q;
endmodule

// File: rtl/vfmt_phase_seq.sv
module vfmt_phase_seq #(
  parameter int unsigned SEQ_LEN = 4,
  localparam int unsigned PW = $clog2(SEQ_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  output logic [PW-1:0] idx
);
  logic          act_d_q;
  logic [PW-1:0] ph_q, ph_n;

  // Restart the order on the first active edge after an inactive one.
  assign idx = (act && !act_d_q) ? '0 : ph_q;

  always_comb begin
    ph_n = '0;
    if (act) ph_n = idx + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d_q <= 1'b0;
      ph_q    <= '0;
    end else begin
      act_d_q <= act;
      ph_q    <= ph_n;
    end
  end
endmodule

// File: rtl/mux_video_formatter.sv
module mux_video_formatter
  import vfmt_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          generic_mode,
  input  logic          cfg_hi,
  input  logic          cfg_lo,
  input  logic          sync_n,
  input  logic          blank_n,
  input  logic [DW-1:0] port_a,
  input  logic [DW-1:0] port_b,
  input  logic [DW-1:0] port_c,
  output logic [DW-1:0] comp0_out,
  output logic [DW-1:0] comp1_out,
  output logic [DW-1:0] comp2_out,
  output logic          out_valid,
  output logic          sync_flag
);
  localparam int unsigned    SEQ_LEN  = 4;
  localparam int unsigned    PW       = $clog2(SEQ_LEN);
  localparam logic [DW-1:0]  LUMA_BLK = DW'(1) << (DW - 4);
  localparam logic [DW-1:0]  CHR_MID  = DW'(1) << (DW - 1);

  fmt_e          fmt;
  logic          act;
  logic [PW-1:0] idx;

  logic [DW-1:0] c0_q, c1_q, c2_q, c0_n, c1_n, c2_n;
  logic [DW-1:0] cb_q, cr_q, cb_n, cr_n;
  logic          vld_q, vld_n, sf_q, sf_n;

  assign act = sync_n && blank_n;

  vfmt_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .generic_mode (generic_mode),
    .cfg          ({cfg_hi, cfg_lo}),
    .sync_n       (sync_n),
    .fmt_eff      (fmt)
  );

  vfmt_phase_seq #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .idx   (idx)
  );

  always_comb begin
    c0_n  = c0_q;
    c1_n  = c1_q;
    c2_n  = c2_q;
    cb_n  = cb_q;
    cr_n  = cr_q;
    vld_n = 1'b0;
    sf_n  = 1'b0;
    if (!sync_n) begin
      c0_n = '0;
      c1_n = '0;
      c2_n = '0;
      cb_n = CHR_MID;
      cr_n = CHR_MID;
      sf_n = !generic_mode;
    end else if (!blank_n) begin
      c0_n = LUMA_BLK;
      c1_n = (fmt == FMT_GBR444) ? LUMA_BLK : CHR_MID;
      c2_n = (fmt == FMT_GBR444) ? LUMA_BLK : CHR_MID;
      cb_n = CHR_MID;
      cr_n = CHR_MID;
    end else begin
      unique case (fmt)
        FMT_GBR444, FMT_YC444: begin
          c0_n  = port_a;
          c1_n  = port_b;
          c2_n  = port_c;
          vld_n = 1'b1;
        end
        FMT_YC422_2: begin
          c0_n  = port_a;
          vld_n = 1'b1;
          if (!idx[0]) begin
            c1_n = port_c;
            c2_n = cr_q;
            cb_n = port_c;
          end else begin
            c1_n = cb_q;
            c2_n = port_c;
            cr_n = port_c;
          end
        end
        FMT_YC422_1: begin
          if (idx[0]) begin
            c0_n  = port_a;
            c1_n  = cb_q;
            c2_n  = cr_q;
            vld_n = 1'b1;
          end else if (idx[1]) begin
            cr_n = port_a;
          end else begin
            cb_n = port_a;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q  <= '0;
      c1_q  <= '0;
      c2_q  <= '0;
      cb_q  <= CHR_MID;
      cr_q  <= CHR_MID;
      vld_q <= 1'b0;
      sf_q  <= 1'b0;
    end else begin
      c0_q  <= c0_n;
      c1_q  <= c1_n;
      c2_q  <= c2_n;
      cb_q  <= cb_n;
      cr_q  <= cr_n;
      vld_q <= vld_n;
      sf_q  <= sf_n;
    end
  end

  assign comp0_out = c0_q;
  assign comp1_out = c1_q;
  assign comp2_out = c2_q;
  assign out_valid = vld_q;
  assign sync_flag = sf_q;
endmodule

// File: rtl/mux_video_formatter_chk.sv
module mux_video_formatter_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          generic_mode,
  input logic          cfg_hi,
  input logic          cfg_lo,
  input logic          sync_n,
  input logic          blank_n,
  input logic [DW-1:0] port_a,
  input logic [DW-1:0] port_b,
  input logic [DW-1:0] port_c,
  input logic [DW-1:0] comp0_out,
  input logic [DW-1:0] comp1_out,
  input logic [DW-1:0] comp2_out,
  input logic          out_valid,
  input logic          sync_flag
);
  a_r7_sync_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (comp0_out == '0 && comp1_out == '0 && comp2_out == '0 && !out_valid));

  a_r7_flag_video: assert property (@(posedge clk) disable iff (!rst_n)
    (!generic_mode && !sync_n) |=> sync_flag);

  a_r6_blank_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> !out_valid);

  a_r9_generic_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    generic_mode |=> !sync_flag);

  a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (generic_mode && !cfg_hi && sync_n && blank_n) |=>
      (out_valid && comp0_out == $past(port_a) && comp1_out == $past(port_b)
       && comp2_out == $past(port_c)));

  a_r4_alt_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (generic_mode && cfg_hi && cfg_lo && out_valid) |=> !out_valid);
endmodule

bind mux_video_formatter mux_video_formatter_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .generic_mode (generic_mode),
  .cfg_hi       (cfg_hi),
  .cfg_lo       (cfg_lo),
  .sync_n       (sync_n),
  .blank_n      (blank_n),
  .port_a       (port_a),
  .port_b       (port_b),
  .port_c       (port_c),
  .comp0_out    (comp0_out),
  .comp1_out    (comp1_out),
  .comp2_out    (comp2_out),
  .out_valid    (out_valid),
  .sync_flag    (sync_flag)
);

// File: tb/mux_video_formatter_test.sv
module mux_video_formatter_test;
  localparam int DW = 10;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          generic_mode, cfg_hi, cfg_lo, sync_n, blank_n;
  logic [DW-1:0] port_a, port_b, port_c;
  logic [DW-1:0] comp0_out, comp1_out, comp2_out;
  logic          out_valid, sync_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mux_video_formatter #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .generic_mode(generic_mode),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .sync_n(sync_n), .blank_n(blank_n),
    .port_a(port_a), .port_b(port_b), .port_c(port_c),
    .comp0_out(comp0_out), .comp1_out(comp1_out), .comp2_out(comp2_out),
    .out_valid(out_valid), .sync_flag(sync_flag)
  );

  // {generic, cfg[1:0], sync_n, blank_n, a, b, c, exp_valid, exp0, exp1, exp2, exp_flag}
  localparam logic [66:0] TBL [0:NV-1] = '{
    {1'b1,2'b00,1'b1,1'b1,10'h001,10'h002,10'h003, 1'b1,10'h001,10'h002,10'h003,1'b0},
    {1'b1,2'b01,1'b1,1'b1,10'h3FF,10'h000,10'h155, 1'b1,10'h3FF,10'h000,10'h155,1'b0},
    {1'b1,2'b01,1'b1,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h040,10'h200,10'h200,1'b0},
    {1'b1,2'b00,1'b1,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h040,10'h040,10'h040,1'b0},
    {1'b1,2'b00,1'b0,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h000,10'h000,10'h000,1'b0},
    {1'b1,2'b10,1'b1,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h040,10'h200,10'h200,1'b0},
    {1'b1,2'b10,1'b1,1'b1,10'h100,10'h3FF,10'h0A0, 1'b1,10'h100,10'h0A0,10'h200,1'b0},
    {1'b1,2'b10,1'b1,1'b1,10'h101,10'h3FF,10'h0B0, 1'b1,10'h101,10'h0A0,10'h0B0,1'b0},
    {1'b1,2'b10,1'b1,1'b1,10'h102,10'h3FF,10'h0C0, 1'b1,10'h102,10'h0C0,10'h0B0,1'b0},
    {1'b1,2'b10,1'b1,1'b1,10'h103,10'h3FF,10'h0D0, 1'b1,10'h103,10'h0C0,10'h0D0,1'b0},
    {1'b1,2'b10,1'b1,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h040,10'h200,10'h200,1'b0},
    {1'b1,2'b10,1'b1,1'b1,10'h104,10'h3FF,10'h0E0, 1'b1,10'h104,10'h0E0,10'h200,1'b0},
    {1'b1,2'b11,1'b1,1'b0,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h040,10'h200,10'h200,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h2A0,10'h3FF,10'h3FF, 1'b0,10'h040,10'h200,10'h200,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h111,10'h3FF,10'h3FF, 1'b1,10'h111,10'h2A0,10'h200,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h2B0,10'h3FF,10'h3FF, 1'b0,10'h111,10'h2A0,10'h200,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h122,10'h3FF,10'h3FF, 1'b1,10'h122,10'h2A0,10'h2B0,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h2C0,10'h3FF,10'h3FF, 1'b0,10'h122,10'h2A0,10'h2B0,1'b0},
    {1'b1,2'b11,1'b1,1'b1,10'h133,10'h3FF,10'h3FF, 1'b1,10'h133,10'h2C0,10'h2B0,1'b0},
    {1'b1,2'b11,1'b0,1'b1,10'h3FF,10'h3FF,10'h3FF, 1'b0,10'h000,10'h000,10'h000,1'b0}
  };
  // requirement tag per table row
  localparam string TAG [0:NV-1] = '{
    "R2","R2","R6","R6","R7/R9","R6","R3/R5","R3","R3","R3",
    "R6","R5","R6","R4/R5","R4","R4","R4","R4","R4","R7/R9"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic v, input logic [DW-1:0] e0,
                         input logic [DW-1:0] e1, input logic [DW-1:0] e2, input logic f);
    chk(req, "valid", int'(out_valid), int'(v));
    chk(req, "comp0", int'(comp0_out), int'(e0));
    chk(req, "comp1", int'(comp1_out), int'(e1));
    chk(req, "comp2", int'(comp2_out), int'(e2));
    chk(req, "sync_flag", int'(sync_flag), int'(f));
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; generic_mode = 1'b1; cfg_hi = 1'b0; cfg_lo = 1'b0;
    sync_n = 1'b1; blank_n = 1'b0; port_a = '0; port_b = '0; port_c = '0;
    repeat (3) @(negedge clk);
    chk_all("R1", 1'b0, '0, '0, '0, 1'b0);
    rst_n = 1'b1;

    // table walk: inputs driven at a negedge, results one edge later
    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      v = TBL[i];
      generic_mode = v[66]; {cfg_hi, cfg_lo} = v[65:64];
      sync_n = v[63]; blank_n = v[62];
      port_a = v[61:52]; port_b = v[51:42]; port_c = v[41:32];
      step();
      chk_all(TAG[i], v[31], v[30:21], v[20:11], v[10:1], v[0]);
    end

    // R1: asynchronous reset with non-zero outputs
    sync_n = 1'b1; blank_n = 1'b1; cfg_hi = 1'b0; cfg_lo = 1'b0;
    port_a = 10'h2AA; port_b = 10'h155; port_c = 10'h3FF;
    step();
    chk_all("R2", 1'b1, 10'h2AA, 10'h155, 10'h3FF, 1'b0);
    #1 rst_n = 1'b0;
    #0.5;
    chk_all("R1", 1'b0, '0, '0, '0, 1'b0);

    // R8: video-mode latching on the second edge after a sync change
    generic_mode = 1'b0; cfg_hi = 1'b1; cfg_lo = 1'b1; sync_n = 1'b1; blank_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk_all("R8", 1'b0, 10'h040, 10'h040, 10'h040, 1'b0);
    sync_n = 1'b0;
    step();
    chk_all("R7", 1'b0, '0, '0, '0, 1'b1);
    cfg_hi = 1'b0; cfg_lo = 1'b1;
    step();
    chk_all("R7", 1'b0, '0, '0, '0, 1'b1);
    cfg_hi = 1'b1; cfg_lo = 1'b1;
    step();
    chk_all("R7", 1'b0, '0, '0, '0, 1'b1);
    sync_n = 1'b1;
    step();
    chk_all("R8", 1'b0, 10'h040, 10'h200, 10'h200, 1'b0);
    cfg_hi = 1'b0; cfg_lo = 1'b0;
    step();
    chk_all("R8", 1'b0, 10'h040, 10'h200, 10'h200, 1'b0);
    step();
    chk_all("R8", 1'b0, 10'h040, 10'h040, 10'h040, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule